// File: doc/BRIEF.md
# Windowed Watchdog Supervisor

This block supervises a processor through a single service line. After a power-on delay it releases an active-low reset and runs a repeating timing sequence: a closed window, then an open window. A falling edge on the service line inside the open window restarts the sequence with no reset. An edge inside the closed window counts as a fault, because the software ran too fast. If the open window ends with no edge, the software ran too slow. Either fault produces a reset pulse of fixed width, and a fresh sequence follows. When service is absent for good, reset therefore repeats as a square wave.

A digital undervoltage flag overrides the timer once it has been high for a filter time. Reset then drops at once, and the block holds it until the flag clears and a full power-on delay has run again. A second active-low output, enable, gates critical loads. It stays inactive while reset is active. After any reset it also stays inactive until the software has serviced the watchdog correctly three times in a row.

All lengths are parameters counted in clock cycles.

Top module: `wdw_sup`

## Requirements
- R1: Following a synchronous reset, rst_n_o stays low for exactly POR_CYC clock cycles. Service edges that arrive during this delay have no effect.
- R2: The service line passes through a two-flop synchronizer, and the timer acts on a falling edge of the input 3 clock edges after the input falls. The closed window lasts CLOSED_CYC cycles, and the open window that follows it lasts OPEN_CYC cycles.
- R3: A service edge acted on while the open window is running restarts a closed window and leaves rst_n_o high. This includes the first and the last cycle of the open window.
- R4: A service edge acted on while the closed window is running drives rst_n_o low for exactly PULSE_CYC cycles. This includes the last cycle of the closed window. A new closed window then starts.
- R5: With no service, rst_n_o stays high for CLOSED_CYC+OPEN_CYC cycles and then goes low for PULSE_CYC cycles, and this repeats. A later open-window service ends the repetition.
- R6: When uv_i has been high for FILT_CYC consecutive clock edges, rst_n_o goes low and en_n_o goes high in that same cycle. A high period of fewer than FILT_CYC edges has no effect on either output.
- R7: After an undervoltage event, rst_n_o stays low while uv_i is high. It then rises POR_CYC+2 clock edges after uv_i falls. Service edges during this time are ignored.
- R8: en_n_o is high whenever rst_n_o is low. It goes low only on the third consecutive open-window service after the most recent reset, fault, missed window or undervoltage. Any of those events sets it high again and restarts the count.
- R9: While rst is high, rst_n_o is low and en_n_o is high. This holds at start-up and when rst is raised in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset; restarts the power-on delay |
| svc_n_i | input | 1 | Service line from the processor; a falling edge is a service |
| uv_i | input | 1 | Undervoltage flag, high while the supply is low |
| rst_n_o | output | 1 | Active-low reset to the processor |
| en_n_o | output | 1 | Active-low enable for critical loads |

## Verification
The assertions check the following on every cycle:
- a closed-window edge always moves the block into a reset pulse;
- an open-window edge always restarts a closed window with reset high;
- a filtered undervoltage always lands in the held state;
- reset only releases from the power-on delay or from a pulse;
- enable is never already active when reset releases;
- enable turns active only right after a good service.

Some properties only the bench scenarios can show. These are the exact lengths of the power-on delay, the windows and the pulse, and the boundary cycles on each side of the window edge. They also include the square-wave period and the rejection of a short undervoltage glitch. The last is the count of three consecutive services and how faults, misses and undervoltage clear it.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [2:0] {
        ST_UV     = 3'd0,
        ST_POR    = 3'd1,
        ST_CLOSED = 3'd2,
        ST_OPEN   = 3'd3,
        ST_PULSE  = 3'd4
    } wdw_state_e;

    typedef struct packed {
        logic good;
        logic fault;
        logic miss;
    } wdw_evt_t;

    function automatic logic is_running(wdw_state_e s);
        return (s == ST_CLOSED) || (s == ST_OPEN);
    endfunction

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int unsigned cnt_width(int unsigned maxval);
        return (maxval > 1) ? $clog2(maxval + 1) : 1;
    endfunction

endpackage

// File: rtl/wdw_sync_fall.sv
module wdw_sync_fall #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    // sr[STAGES-1] is the synchronized value, sr[STAGES] its previous value
    logic [STAGES:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-1:0], din};
    end

    assign fall = sr[STAGES] & ~sr[STAGES-1];
endmodule

// File: rtl/wdw_uv_filter.sv
module wdw_uv_filter
    import wdw_pkg::*;
#(
    parameter int unsigned FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_i,
    output logic uv_hit
);
    localparam int unsigned FW = cnt_width(FILT_CYC);

    logic [FW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !uv_i)             cnt <= '0;
        else if (cnt != FW'(FILT_CYC)) cnt <= cnt + 1'b1;
    end

    assign uv_hit = (cnt == FW'(FILT_CYC));
endmodule

// File: rtl/wdw_timer.sv
module wdw_timer
    import wdw_pkg::*;
#(
    parameter int unsigned CLOSED_CYC = 20,
    parameter int unsigned OPEN_CYC   = 20,
    parameter int unsigned PULSE_CYC  = 5,
    parameter int unsigned POR_CYC    = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       svc_fall,
    input  logic       uv_hit,
    output wdw_state_e st,
    output wdw_evt_t   evt
);
    localparam int unsigned TMAX = max4(CLOSED_CYC, OPEN_CYC, PULSE_CYC, POR_CYC);
    localparam int unsigned CW   = cnt_width(TMAX);

    logic [CW-1:0] cnt, cnt_n;
    wdw_state_e    st_n;

    always_comb begin
        st_n  = st;
        cnt_n = cnt + 1'b1;
        evt   = '0;
        if (uv_hit) begin
            st_n  = ST_UV;
            cnt_n = '0;
        end else begin
            unique case (st)
                ST_UV: begin
                    st_n  = ST_POR;
                    cnt_n = '0;
                end
                ST_POR: begin
                    if (cnt == CW'(POR_CYC - 1)) begin
                        st_n  = ST_CLOSED;
                        cnt_n = '0;
                    end
                end
                ST_CLOSED: begin
                    if (svc_fall) begin
                        evt.fault = 1'b1;
                        st_n      = ST_PULSE;
                        cnt_n     = '0;
                    end else if (cnt == CW'(CLOSED_CYC - 1)) begin
                        st_n  = ST_OPEN;
                        cnt_n = '0;
                    end
                end
                ST_OPEN: begin
                    if (svc_fall) begin
                        evt.good = 1'b1;
                        st_n     = ST_CLOSED;
                        cnt_n    = '0;
                    end else if (cnt == CW'(OPEN_CYC - 1)) begin
                        evt.miss = 1'b1;
                        st_n     = ST_PULSE;
                        cnt_n    = '0;
                    end
                end
                ST_PULSE: begin
                    if (cnt == CW'(PULSE_CYC - 1)) begin
                        st_n  = ST_CLOSED;
                        cnt_n = '0;
                    end
                end
                default: begin
                    st_n  = ST_POR;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_POR;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end
endmodule

// File: rtl/wdw_enable_qual.sv
module wdw_enable_qual
    import wdw_pkg::*;
#(
    parameter int unsigned GOOD_NEED = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  wdw_evt_t   evt,
    input  logic       uv_hit,
    input  wdw_state_e st,
    output logic       en_ok
);
    localparam int unsigned GW = cnt_width(GOOD_NEED);

    logic [GW-1:0] good_cnt;
    logic          clr;

    assign clr = uv_hit || evt.fault || evt.miss || !is_running(st);

    always_ff @(posedge clk) begin
        if (rst || clr)
            good_cnt <= '0;
        else if (evt.good && good_cnt != GW'(GOOD_NEED))
            good_cnt <= good_cnt + 1'b1;
    end

    assign en_ok = (good_cnt == GW'(GOOD_NEED));
endmodule

// File: rtl/wdw_sup.sv
module wdw_sup
    import wdw_pkg::*;
#(
    parameter int unsigned CLOSED_CYC  = 2000,
    parameter int unsigned OPEN_CYC    = 2000,
    parameter int unsigned PULSE_CYC   = 100,
    parameter int unsigned POR_CYC     = 5000,
    parameter int unsigned FILT_CYC    = 150,
    parameter int unsigned GOOD_NEED   = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic svc_n_i,
    input  logic uv_i,
    output logic rst_n_o,
    output logic en_n_o
);
    logic       svc_fall;
    logic       uv_hit;
    logic       en_ok;
    wdw_state_e st;
    wdw_evt_t   evt;

    wdw_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(svc_n_i), .fall(svc_fall)
    );

    wdw_uv_filter #(.FILT_CYC(FILT_CYC)) u_uv (
        .clk(clk), .rst(rst), .uv_i(uv_i), .uv_hit(uv_hit)
    );

    wdw_timer #(
        .CLOSED_CYC(CLOSED_CYC), .OPEN_CYC(OPEN_CYC),
        .PULSE_CYC(PULSE_CYC),   .POR_CYC(POR_CYC)
    ) u_timer (
        .clk(clk), .rst(rst), .svc_fall(svc_fall), .uv_hit(uv_hit),
        .st(st), .evt(evt)
    );

    wdw_enable_qual #(.GOOD_NEED(GOOD_NEED)) u_qual (
        .clk(clk), .rst(rst), .evt(evt), .uv_hit(uv_hit), .st(st),
        .en_ok(en_ok)
    );

    // undervoltage overrides the registered state in the same cycle
    assign rst_n_o = is_running(st) && !uv_hit;
    assign en_n_o  = !(en_ok && rst_n_o);
endmodule

// File: rtl/wdw_sup_chk.sv
module wdw_sup_chk
    import wdw_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rst_n_o,
    input logic       en_n_o,
    input wdw_state_e st,
    input logic       svc_fall,
    input logic       uv_hit,
    input logic       good_ev
);
    assert_early_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CLOSED && svc_fall && !uv_hit) |=> (st == ST_PULSE && !rst_n_o));

    assert_open_service_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPEN && svc_fall && !uv_hit) |=> (st == ST_CLOSED && rst_n_o));

    assert_uv_hold_R6: assert property (@(posedge clk) disable iff (rst)
        uv_hit |=> (st == ST_UV && !rst_n_o && en_n_o));

    assert_release_source_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_o) |-> ($past(st) == ST_POR || $past(st) == ST_PULSE));

    assert_release_no_enable_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_o) |-> en_n_o);

    assert_enable_after_good_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(en_n_o) |-> $past(good_ev));
endmodule

bind wdw_sup wdw_sup_chk u_chk (
    .clk(clk), .rst(rst), .rst_n_o(rst_n_o), .en_n_o(en_n_o),
    .st(st), .svc_fall(svc_fall), .uv_hit(uv_hit), .good_ev(evt.good)
);

// File: tb/tb_wdw_sup.sv
module tb_wdw_sup;
    localparam int C  = 20;
    localparam int O  = 20;
    localparam int P  = 5;
    localparam int PR = 30;
    localparam int F  = 4;
    localparam int NV = 12;

    // gap = edges from window start to the edge that acts on the service
    localparam int VGAP  [0:NV-1] = '{25, 30, 21, 40, 10, 21, 20, 40, 40, 33, 5, 3};
    localparam bit VGOOD [0:NV-1] = '{ 1,  1,  1,  1,  0,  1,  0,  1,  1,  1, 0, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic svc_n_i = 1'b1;
    logic uv_i = 1'b0;
    logic rst_n_o, en_n_o;

    int cyc = 0;
    int nchk = 0;
    int nbad = 0;
    int wstart = 0;
    int gcount = 0;
    bit done = 1'b0;

    wdw_sup #(
        .CLOSED_CYC(C), .OPEN_CYC(O), .PULSE_CYC(P), .POR_CYC(PR), .FILT_CYC(F)
    ) dut (
        .clk(clk), .rst(rst), .svc_n_i(svc_n_i), .uv_i(uv_i),
        .rst_n_o(rst_n_o), .en_n_o(en_n_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic at_edge(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic chk_outs(input string tag, input bit exp_rst, input bit exp_en);
        chk(rst_n_o == exp_rst, {tag, " rst_n_o"}, int'(rst_n_o), int'(exp_rst));
        chk(en_n_o == exp_en, {tag, " en_n_o"}, int'(en_n_o), int'(exp_en));
    endtask

    task automatic run_vec(input int gap, input bit good, input string tag);
        int a;
        a = wstart + gap;
        at_edge(a - 3);
        svc_n_i = 1'b0;
        at_edge(a - 1);
        svc_n_i = 1'b1;
        chk(rst_n_o == 1'b1, {tag, " before act"}, int'(rst_n_o), 1);
        at_edge(a);
        if (good) begin
            if (gcount < 3) gcount++;
            chk_outs({tag, " R3 open service"}, 1'b1, !(gcount == 3));
            wstart = a;
        end else begin
            gcount = 0;
            chk_outs({tag, " R4 closed fault"}, 1'b0, 1'b1);
            at_edge(a + P - 1);
            chk(rst_n_o == 1'b0, {tag, " R4 pulse end"}, int'(rst_n_o), 0);
            at_edge(a + P);
            chk(rst_n_o == 1'b1, {tag, " R4 release"}, int'(rst_n_o), 1);
            wstart = a + P;
        end
    endtask

    initial begin
        int r0, u, v, k, n;
        @(negedge clk);
        repeat (4) @(negedge clk);
        chk_outs("R9 reset state", 1'b0, 1'b1);
        r0 = cyc;
        rst = 1'b0;
        // service during power-on delay is ignored (R1)
        at_edge(r0 + 10);
        svc_n_i = 1'b0;
        at_edge(r0 + 12);
        svc_n_i = 1'b1;
        n = 0;
        while (rst_n_o == 1'b0 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        wstart = cyc;
        chk((wstart - r0) == PR, "R1 power-on delay", wstart - r0, PR);
        chk(en_n_o == 1'b1, "R8 enable after power-on", int'(en_n_o), 1);

        // R2 R3 R4 R8: vector table
        for (int i = 0; i < NV; i++)
            run_vec(VGAP[i], VGOOD[i], $sformatf("R2 vec%0d", i));

        // R5: square wave with no service
        for (int p = 0; p < 2; p++) begin
            at_edge(wstart + C + O - 1);
            chk(rst_n_o == 1'b1, "R5 high before pulse", int'(rst_n_o), 1);
            at_edge(wstart + C + O);
            chk_outs("R5 pulse start", 1'b0, 1'b1);
            at_edge(wstart + C + O + P - 1);
            chk(rst_n_o == 1'b0, "R5 pulse width", int'(rst_n_o), 0);
            at_edge(wstart + C + O + P);
            chk(rst_n_o == 1'b1, "R5 period", int'(rst_n_o), 1);
            wstart = wstart + C + O + P;
        end
        gcount = 0;
        run_vec(25, 1'b1, "R5 recovery");
        run_vec(25, 1'b1, "R8 second");
        run_vec(25, 1'b1, "R8 third");

        // R6: short glitch ignored
        u = wstart + 2;
        at_edge(u);
        uv_i = 1'b1;
        at_edge(u + F - 1);
        uv_i = 1'b0;
        at_edge(u + F);
        chk_outs("R6 glitch ignored", 1'b1, 1'b0);
        at_edge(u + F + 1);
        chk_outs("R6 glitch ignored later", 1'b1, 1'b0);

        // R6: filtered undervoltage
        u = wstart + 8;
        at_edge(u);
        uv_i = 1'b1;
        at_edge(u + F - 1);
        chk(rst_n_o == 1'b1, "R6 before filter", int'(rst_n_o), 1);
        at_edge(u + F);
        chk_outs("R6 uv forces reset", 1'b0, 1'b1);
        at_edge(u + 8);
        svc_n_i = 1'b0;
        at_edge(u + 10);
        svc_n_i = 1'b1;
        v = u + 15;
        at_edge(v);
        chk(rst_n_o == 1'b0, "R7 held during uv", int'(rst_n_o), 0);
        uv_i = 1'b0;
        at_edge(v + 12);
        svc_n_i = 1'b0;
        at_edge(v + 14);
        svc_n_i = 1'b1;
        at_edge(v + 1 + PR);
        chk(rst_n_o == 1'b0, "R7 still in delay", int'(rst_n_o), 0);
        at_edge(v + 2 + PR);
        chk_outs("R7 release after uv", 1'b1, 1'b1);
        wstart = v + 2 + PR;
        gcount = 0;
        run_vec(25, 1'b1, "R8 count restarted");
        run_vec(22, 1'b1, "R8 count two");
        run_vec(38, 1'b1, "R8 count three");

        // R9: reset mid-operation
        k = cyc + 2;
        at_edge(k);
        rst = 1'b1;
        at_edge(k + 1);
        chk_outs("R9 mid reset", 1'b0, 1'b1);
        rst = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end
endmodule